// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

The block is a set-associative data cache that sits between a 32-bit byte-addressed processor port and a slower memory that moves whole lines. With its default parameters it holds 8 KB as 32 sets of 4 ways, with 64-byte lines. The processor issues one word load or store at a time through a valid/ready handshake. Every completed access produces a response pulse that carries the load word and a flag saying whether the access first missed.

On a miss the controller always runs the same steps. It chooses a frame in the indexed set, taking the lowest-numbered empty way if there is one and otherwise asking an external replacement unit. If the chosen frame holds modified data, it writes that data back. It then reads the requested line from memory, installs it, and runs the original access again, which now hits. Stores allocate on a miss. A run-time mode input selects copy-back or store-through handling of stores.

Top module: `cache_wb_ctrl`

## Requirements
- R1: After reset every frame is empty and unmodified, `req_ready` is 1 and `mem_req` is 0. The first access to any address therefore reports `rsp_miss`=1.
- R2: A byte address splits into bits as follows. The low OFF_W bits are the byte offset, and bits [OFF_W-1:2] of the offset pick the word. The next IDX_W bits pick the set, and the remaining TAG_W bits form the tag. The memory port line address is address bits [ADDR_W-1:OFF_W].
- R3: An access hits when a valid way of its set holds its tag. At most one way matches, and a response is given only for a hitting access.
- R4: A load returns the most recent value stored to that word address, or the memory's value if that word was never stored to.
- R5: A miss holds `req_ready` low while it runs. It issues at most one write-back and then exactly one line read. The response then comes from the replayed access with `rsp_miss`=1, and an access that hit at once reports `rsp_miss`=0.
- R6: The frame for a new line is the lowest-numbered invalid way of the set. Only when every way is valid does `repl_query` rise, for one cycle, with `repl_set` giving the set. The frame is then the way given on `repl_way`.
- R7: In copy-back mode (`wb_mode`=1) a store marks its line modified and causes no memory write. Evicting a modified line writes the whole line once to its own line address.
- R8: In store-through mode (`wb_mode`=0) each store writes its whole updated line once to memory before its response. The store does not mark the line, so evicting an unmarked line causes no memory write.
- R9: A store miss reads the full line first and then merges the stored word into it; the rest of the line keeps the memory's data.
- R10: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`. Only one request is outstanding at a time.
- R11: A line marked modified in copy-back mode is still written back on eviction after the mode is switched to store-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = copy-back stores, 0 = store-through stores |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (32) | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Word at the access address |
| rsp_miss | output | 1 | The access missed before completing |
| repl_query | output | 1 | Victim wanted from the replacement unit |
| repl_set | output | IDX_W (5) | Set for which a victim is wanted |
| repl_way | input | WAY_W (2) | Victim way from the replacement unit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W (26) | Line address |
| mem_wdata | output | LINE_BYTES*8 (512) | Line to write |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | LINE_BYTES*8 (512) | Line read, valid with mem_ack |

## Verification
The bench builds the controller with 4 sets of 2 ways and 16-byte lines, over a 64-line memory. That gives each set 16 competing tags, so fills, evictions of clean and modified frames, and replacement queries all occur again and again. A first pass steps through every word of the memory, and mixed load/store traffic then runs in copy-back mode, in store-through mode and in copy-back mode again. A shadow of tags, valid and modified bits predicts every miss flag, query, line read and line write. A final pass compares memory with the expected contents.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WTHRU,
    ST_EVICT,
    ST_FILL
  } cst_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        mark_en,
  input  logic [WAY_W-1:0]            mark_way,
  output logic [WAYS-1:0]             match_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_vec
);
  logic [WAYS-1:0] vld [SETS];
  logic [WAYS-1:0] dty [SETS];
  logic [TAG_W-1:0] tg [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        dty[s] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld[idx][fill_way] <= 1'b1;
        dty[idx][fill_way] <= 1'b0;
      end
      if (mark_en) dty[idx][mark_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tg[idx][fill_way] <= fill_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign valid_vec[w] = vld[idx][w];
    assign dirty_vec[w] = dty[idx][w];
    assign tag_vec[w]   = tg[idx][w];
    assign match_vec[w] = vld[idx][w] && (tg[idx][w] == cmp_tag);
  end
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int LINE_W = 512,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WPL    = LINE_W / 32,
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx,
  input  logic                         wr_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [WSEL_W-1:0]            wr_sel,
  input  logic [31:0]                  wr_data,
  input  logic                         fill_en,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic [LINE_W-1:0]            fill_line,
  output logic [WAYS-1:0][LINE_W-1:0]  rd_lines
);
  localparam int FRAMES = SETS * WAYS;
  logic [LINE_W-1:0] arr [FRAMES];

  function automatic int frame(input logic [IDX_W-1:0] s, input logic [WAY_W-1:0] w);
    return int'(s) * WAYS + int'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (fill_en)
      arr[frame(idx, fill_way)] <= fill_line;
    else if (wr_en)
      arr[frame(idx, wr_way)][int'(wr_sel)*32 +: 32] <= wr_data;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_lines[w] = arr[frame(idx, WAY_W'(w))];
  end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] repl_way,
  output logic [WAY_W-1:0] victim,
  output logic             all_valid
);
  function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!v[w]) r = WAY_W'(w);
    return r;
  endfunction

  assign all_valid = &valid_vec;
  assign victim    = all_valid ? repl_way : first_free(valid_vec);
endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int WSEL_W  = OFF_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wb_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_miss,
  output logic               repl_query,
  output logic [IDX_W-1:0]   repl_set,
  input  logic [WAY_W-1:0]   repl_way,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [LINE_W-1:0]  mem_rdata
);
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[2 +: WSEL_W];
  endfunction
  function automatic logic [WAY_W-1:0] encode(input logic [WAYS-1:0] m);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++)
      if (m[w]) r = r | WAY_W'(w);
    return r;
  endfunction

  cst_e              st;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [31:0]       q_wdata;
  logic              missed;
  logic [WAY_W-1:0]  vict_r;

  logic [IDX_W-1:0]            q_idx;
  logic [TAG_W-1:0]            q_tag;
  logic [WSEL_W-1:0]           q_sel;
  logic [WAYS-1:0]             match_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0]  tag_vec;
  logic [WAYS-1:0][LINE_W-1:0] rd_lines;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic [WAY_W-1:0]            pick_way;
  logic                        all_valid;

  // named events for the checker
  logic fill_go, store_go, mark_go, evict_cmd, victim_dirty, accept;

  assign q_idx   = addr_idx(q_addr);
  assign q_tag   = addr_tag(q_addr);
  assign q_sel   = addr_word(q_addr);
  assign hit     = |match_vec;
  assign hit_way = encode(match_vec);

  assign accept       = req_valid && req_ready;
  assign fill_go      = (st == ST_FILL) && mem_ack;
  assign store_go     = (st == ST_LOOK) && hit && q_we;
  assign mark_go      = store_go && wb_mode;
  assign evict_cmd    = (st == ST_EVICT);
  assign victim_dirty = dirty_vec[vict_r];

  cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(q_idx), .cmp_tag(q_tag),
    .fill_en(fill_go), .fill_way(vict_r), .fill_tag(q_tag),
    .mark_en(mark_go), .mark_way(hit_way),
    .match_vec(match_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
  );

  cache_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .idx(q_idx),
    .wr_en(store_go), .wr_way(hit_way), .wr_sel(q_sel), .wr_data(q_wdata),
    .fill_en(fill_go), .fill_way(vict_r), .fill_line(mem_rdata),
    .rd_lines(rd_lines)
  );

  cache_victim_pick #(.WAYS(WAYS)) u_pick (
    .valid_vec(valid_vec), .repl_way(repl_way), .victim(pick_way), .all_valid(all_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      missed  <= 1'b0;
      vict_r  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          q_we    <= req_we;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          missed  <= 1'b0;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit) begin
            st <= (q_we && !wb_mode) ? ST_WTHRU : ST_IDLE;
          end else begin
            missed <= 1'b1;
            vict_r <= pick_way;
            st     <= (valid_vec[pick_way] && dirty_vec[pick_way]) ? ST_EVICT : ST_FILL;
          end
        end
        ST_WTHRU: if (mem_ack) st <= ST_IDLE;
        ST_EVICT: if (mem_ack) st <= ST_FILL;
        ST_FILL:  if (mem_ack) st <= ST_LOOK;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = ((st == ST_LOOK) && hit && !(q_we && !wb_mode)) ||
                      ((st == ST_WTHRU) && mem_ack);
  assign rsp_rdata  = rd_lines[hit_way][int'(q_sel)*32 +: 32];
  assign rsp_miss   = missed;
  assign repl_query = (st == ST_LOOK) && !hit && all_valid;
  assign repl_set   = q_idx;

  assign mem_req   = (st == ST_EVICT) || (st == ST_FILL) || (st == ST_WTHRU);
  assign mem_we    = (st == ST_EVICT) || (st == ST_WTHRU);
  assign mem_addr  = (st == ST_EVICT) ? {tag_vec[vict_r], q_idx} : q_addr[ADDR_W-1:OFF_W];
  assign mem_wdata = (st == ST_EVICT) ? rd_lines[vict_r] : rd_lines[hit_way];
endmodule

// File: rtl/cache_wb_ctrl_chk.sv
module cache_wb_ctrl_chk #(
  parameter int WAYS    = 4,
  parameter int LADDR_W = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               hit,
  input logic [WAYS-1:0]    match_vec,
  input logic               repl_query,
  input logic               all_valid,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [LADDR_W-1:0] mem_addr,
  input logic               evict_cmd,
  input logic               victim_dirty
);
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match_vec)); // R3
  AST_RSP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> hit); // R3
  AST_BUSY_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !req_ready); // R5
  AST_QUERY_FULL: assert property (@(posedge clk) disable iff (!rst_n) repl_query |-> all_valid); // R6
  AST_EVICT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) evict_cmd |-> victim_dirty); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
endmodule

bind cache_wb_ctrl cache_wb_ctrl_chk #(.WAYS(WAYS), .LADDR_W(LADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid), .hit(hit),
  .match_vec(match_vec), .repl_query(repl_query), .all_valid(all_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .evict_cmd(evict_cmd), .victim_dirty(victim_dirty)
);

// File: tb/sim_cache_wb_ctrl.sv
module sim_cache_wb_ctrl;
  localparam int ADDR_W = 32, LINE_BYTES = 16, SETS = 4, WAYS = 2;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int NLINES = 64, NWORDS = NLINES * 4;

  logic clk = 0, rst_n = 0, wb_mode = 1;
  logic req_valid = 0, req_we = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, rsp_miss, repl_query, mem_req, mem_we;
  logic [31:0] rsp_rdata;
  logic [1:0] repl_set;
  logic [0:0] repl_way = 0;
  logic [27:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata, mem_rdata;
  logic mem_ack;

  always #5 clk = ~clk;

  cache_wb_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_miss(rsp_miss), .repl_query(repl_query), .repl_set(repl_set),
    .repl_way(repl_way), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, q_cnt = 0;
  logic [LINE_W-1:0] bmem [NLINES];
  logic [31:0] refm [NWORDS];
  int  mtag [SETS][WAYS];
  bit  mval [SETS][WAYS];
  bit  mdty [SETS][WAYS];
  bit  done = 0;

  function automatic logic [31:0] ival(input int w);
    return (w * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // lower-level memory: acknowledges on the third cycle of a request
  initial begin
    int wn;
    logic [27:0] sa;
    logic sw;
    wn = 0; sa = 0; sw = 0;
    mem_ack = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (repl_query) q_cnt++;
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (wn == 0) begin sa = mem_addr; sw = mem_we; wn = 1; end
        else if (wn == 1) wn = 2;
        else begin
          chk(mem_addr == sa && mem_we == sw, "R10 request held", {36'd0, mem_addr}, {36'd0, sa});
          mem_ack = 1;
          wn = 0;
          if (mem_we) begin bmem[mem_addr[5:0]] = mem_wdata; wr_cnt++; end
          else begin mem_rdata = bmem[mem_addr[5:0]]; rd_cnt++; end
        end
      end
    end
  end

  task automatic access(input bit we, input int wa, input logic [31:0] wd);
    int line, st, tg, hw, vw, ew, er, eq;
    bit hit, full;
    line = wa / 4; st = line % SETS; tg = line / SETS;
    hit = 0; hw = 0;
    for (int w = 0; w < WAYS; w++) if (mval[st][w] && mtag[st][w] == tg) begin hit = 1; hw = w; end
    full = 1;
    for (int w = 0; w < WAYS; w++) if (!mval[st][w]) full = 0;
    vw = int'(repl_way);
    if (!full) for (int w = WAYS - 1; w >= 0; w--) if (!mval[st][w]) vw = w;
    ew = 0; er = 0; eq = 0;
    if (!hit) begin
      er = 1;
      eq = full ? 1 : 0;
      if (mval[st][vw] && mdty[st][vw]) ew++;
    end
    if (we && !wb_mode) ew++;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; q_cnt = 0;
    req_valid = 1; req_we = we; req_addr = wa * 4; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    while (!rsp_valid) begin @(negedge clk); #1; end

    chk(rsp_miss == !hit, "R2 R3 R5 miss flag", rsp_miss, !hit);
    chk(q_cnt == eq, "R6 replacement query", q_cnt, eq);
    chk(rd_cnt == er, "R5 R9 line reads", rd_cnt, er);
    chk(wr_cnt == ew, "R7 R8 R11 line writes", wr_cnt, ew);
    if (!we) chk(rsp_rdata == refm[wa], "R4 load data", rsp_rdata, refm[wa]);

    if (!hit) begin
      mtag[st][vw] = tg; mval[st][vw] = 1; mdty[st][vw] = 0; hw = vw;
    end
    if (we) begin
      refm[wa] = wd;
      if (wb_mode) mdty[st][hw] = 1;
    end
  endtask

  initial begin
    int seed;
    seed = 7;
    for (int l = 0; l < NLINES; l++)
      for (int k = 0; k < 4; k++) begin
        bmem[l][32*k +: 32] = ival(l * 4 + k);
        refm[l * 4 + k] = ival(l * 4 + k);
      end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mtag[s][w] = 0; mval[s][w] = 0; mdty[s][w] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(mem_req == 0, "R1 memory idle after reset", mem_req, 0);

    wb_mode = 1;
    for (int wa = 0; wa < NWORDS; wa++) begin
      repl_way = 1'(wa >> 3);
      access(0, wa, 0);
    end
    for (int p = 0; p < 3; p++) begin
      wb_mode = (p != 1);
      for (int i = 0; i < 300; i++) begin
        seed = seed * 1103515245 + 12345;
        repl_way = 1'(seed >>> 20);
        access(((seed >>> 16) & 3) < 2, (seed >>> 8) & (NWORDS - 1), seed ^ (i << 8));
      end
    end

    // memory must hold the expected value of every line not held modified
    for (int l = 0; l < NLINES; l++) begin
      bit held;
      held = 0;
      for (int w = 0; w < WAYS; w++)
        if (mval[l % SETS][w] && mtag[l % SETS][w] == l / SETS && mdty[l % SETS][w]) held = 1;
      if (!held)
        for (int k = 0; k < 4; k++)
          chk(bmem[l][32*k +: 32] == refm[l * 4 + k], "R7 R8 R9 memory contents",
              bmem[l][32*k +: 32], refm[l * 4 + k]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule